// File: doc/BRIEF.md
# DMA Channel Transfer Engine

This block is the datapath controller of one DMA channel. It keeps the working source address, destination address and remaining element count. It moves elements one at a time over a simple request/acknowledge memory port. Each element is a read from the source followed by a write of the same data to the destination. After each element, both addresses advance by their own programmed step and the count drops by one.

The configuration arrives on plain input ports. A one-cycle `arm` pulse loads the start addresses and the count and enables the channel. After that, hardware triggers or software start pulses request work. In the plain transfer modes the channel disables itself at the end of a block. In the repeat modes it reloads its start values and stays enabled. A one-cycle completion pulse marks the end of each block. An optional early-warning pulse fires a chosen number of elements before the end. A memory error response is passed through as a one-cycle flag, and the transfer continues.

Top module: `dma_chan_engine`

## Requirements
- R1: Out of reset `mem_req`, `chan_active`, `done_pulse`, `early_pulse` and `err_flag` are low.
- R2: While the channel is not enabled, `hw_trig` and `sw_start` have no effect and no memory request is issued. `arm` enables the channel and loads the start addresses and count from the configuration ports. `arm` is ignored while the channel is enabled.
- R3: `cfg_mode` encoding: 0 single, 1 block, 2 repeat-single, 3 repeat-block. In block modes, one trigger moves all remaining elements back to back.
- R4: In single modes, each trigger moves exactly one element. The block completes only when the last programmed element has been written.
- R5: Each element is a read at the current source address followed by a write at the current destination address. The write carries the read data. `mem_size` gives that side's width: 0 byte, 1 half-word, 2 word, 3 64-bit.
- R6: Step code per side: 0 unchanged, 1 back by one element, 2 forward by one element, 3 to 10 forward by 2 to 9 elements, 11 to 15 unchanged. One element is 2^width bytes. The source and destination sides are independent.
- R7: `rem_cnt` drops by one on each completed write.
- R8: `done_pulse` is high for one cycle after the final write of a block. In non-repeat modes, `chan_active` is low from that same cycle.
- R9: A programmed count of zero completes on the first trigger with no memory access.
- R10: Early-warning code in `cfg_early`: 0 off, 1 to 6 give thresholds of 1, 2, 4, 8, 32 and 64, and 7 gives half of the loaded count (count shifted right by one). `early_pulse` is high for one cycle, with `rem_cnt` equal to the threshold, after the write that brings the count to the threshold. It fires at most once per block, and it never fires if the count starts below the threshold.
- R11: In repeat modes, completion reloads both addresses and the count from the configuration ports and `chan_active` stays high.
- R12: A trigger that arrives while an element is in flight is held, one deep, and is serviced when the channel returns to idle. This includes a trigger in the completing cycle of a repeat block.
- R13: `err_flag` pulses for one cycle after any acknowledge that carries `mem_err`, and the transfer carries on.
- R14: `mem_addr`, `mem_we` and `mem_size` stay stable while `mem_req` is high and `mem_ack` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Pulse: load start values and enable |
| hw_trig | input | 1 | Hardware transfer trigger pulse |
| sw_start | input | 1 | Software start pulse, same effect as a trigger |
| cfg_mode | input | 2 | Transfer mode |
| cfg_src_addr | input | AW | Source start address |
| cfg_dst_addr | input | AW | Destination start address |
| cfg_src_width | input | 2 | Source element width code |
| cfg_dst_width | input | 2 | Destination element width code |
| cfg_src_inc | input | 4 | Source step code |
| cfg_dst_inc | input | 4 | Destination step code |
| cfg_count | input | CW | Elements per block |
| cfg_early | input | 3 | Early-warning threshold code |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Request address |
| mem_size | output | 2 | Access width code |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Request accepted and completed |
| mem_rdata | input | DW | Read data, valid with `mem_ack` |
| mem_err | input | 1 | Error response, valid with `mem_ack` |
| chan_active | output | 1 | Channel enabled |
| done_pulse | output | 1 | Block complete |
| early_pulse | output | 1 | Early warning |
| err_flag | output | 1 | Error response seen |
| cur_src | output | AW | Working source address |
| cur_dst | output | AW | Working destination address |
| rem_cnt | output | CW | Elements left in the block |

## Verification
A new trigger can land in the same cycle as the final write of a repeat block. In that cycle the channel both reloads its start values and records the pending request. The bench provokes this by watching for the last write acknowledge at the falling edge and raising `hw_trig` for exactly that cycle. It then judges the outcome from the logged memory traffic: a second block must follow on its own, its reads must restart at the programmed start address, and exactly two completion pulses must appear. A trigger that meets an in-flight element in single mode under a throttled acknowledge is checked the same way.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } eng_state_e;

  // step code boundaries
  localparam logic [3:0] STEP_HOLD    = 4'd0;
  localparam logic [3:0] STEP_BACK    = 4'd1;
  localparam logic [3:0] STEP_FWD     = 4'd2;
  localparam logic [3:0] STEP_MUL_LO  = 4'd3;
  localparam logic [3:0] STEP_MUL_HI  = 4'd10;

  // early-warning code for "half of block"
  localparam logic [2:0] EARLY_HALF = 3'd7;

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step
  import dma_chan_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    width_i,
  input  logic [3:0]    inc_i,
  output logic [AW-1:0] addr_o
);

  logic          back;
  logic [3:0]    mult;
  logic [AW-1:0] delta;

  always_comb begin
    back = 1'b0;
    mult = 4'd0;
    if (inc_i == STEP_BACK) begin
      back = 1'b1;
      mult = 4'd1;
    end else if (inc_i == STEP_FWD) begin
      mult = 4'd1;
    end else if (inc_i >= STEP_MUL_LO && inc_i <= STEP_MUL_HI) begin
      mult = inc_i - 4'd1;
    end
    delta  = {{(AW-4){1'b0}}, mult} << width_i;
    addr_o = back ? (addr_i - delta) : (addr_i + delta);
  end

endmodule

// File: rtl/dma_early_detect.sv
module dma_early_detect
  import dma_chan_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic [2:0]    code_i,
  input  logic [CW-1:0] len_i,
  input  logic [CW-1:0] rem_i,
  input  logic          fire_i,
  output logic          hit_o
);

  logic [CW-1:0] thr;

  always_comb begin
    case (code_i)
      3'd1:       thr = CW'(1);
      3'd2:       thr = CW'(2);
      3'd3:       thr = CW'(4);
      3'd4:       thr = CW'(8);
      3'd5:       thr = CW'(32);
      3'd6:       thr = CW'(64);
      EARLY_HALF: thr = len_i >> 1;
      default:    thr = '0;
    endcase
    hit_o = fire_i && (thr != '0) && (rem_i == thr);
  end

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 64,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          hw_trig,
  input  logic          sw_start,
  input  logic [1:0]    cfg_mode,
  input  logic [AW-1:0] cfg_src_addr,
  input  logic [AW-1:0] cfg_dst_addr,
  input  logic [1:0]    cfg_src_width,
  input  logic [1:0]    cfg_dst_width,
  input  logic [3:0]    cfg_src_inc,
  input  logic [3:0]    cfg_dst_inc,
  input  logic [CW-1:0] cfg_count,
  input  logic [2:0]    cfg_early,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_err,
  output logic          chan_active,
  output logic          done_pulse,
  output logic          early_pulse,
  output logic          err_flag,
  output logic [AW-1:0] cur_src,
  output logic [AW-1:0] cur_dst,
  output logic [CW-1:0] rem_cnt
);

  localparam int NSIDE = 2;

  eng_state_e    state_q, state_n;
  logic          en_q, en_n;
  logic          pend_q, pend_n;
  logic [AW-1:0] src_q, src_n, dst_q, dst_n;
  logic [CW-1:0] rem_q, rem_n, len_q, len_n;
  logic [DW-1:0] data_q;
  logic          done_q, early_q, err_q;

  logic          trig, rd_ack, wr_ack, finish, rpt, blk, early_hit;
  logic [CW-1:0] rem_dec;

  // address steppers, one per side
  logic [AW-1:0] side_cur [NSIDE];
  logic [AW-1:0] side_nxt [NSIDE];
  logic [1:0]    side_w   [NSIDE];
  logic [3:0]    side_inc [NSIDE];

  assign side_cur[0] = src_q;
  assign side_cur[1] = dst_q;
  assign side_w[0]   = cfg_src_width;
  assign side_w[1]   = cfg_dst_width;
  assign side_inc[0] = cfg_src_inc;
  assign side_inc[1] = cfg_dst_inc;

  for (genvar g = 0; g < NSIDE; g++) begin : g_step
    dma_addr_step #(.AW(AW)) u_step (
      .addr_i  (side_cur[g]),
      .width_i (side_w[g]),
      .inc_i   (side_inc[g]),
      .addr_o  (side_nxt[g])
    );
  end

  assign trig    = hw_trig | sw_start;
  assign rd_ack  = (state_q == ST_READ)  && mem_ack;
  assign wr_ack  = (state_q == ST_WRITE) && mem_ack;
  assign rem_dec = rem_q - CW'(1);
  assign rpt     = cfg_mode[1];
  assign blk     = cfg_mode[0];

  dma_early_detect #(.CW(CW)) u_early (
    .code_i (cfg_early),
    .len_i  (len_q),
    .rem_i  (rem_dec),
    .fire_i (wr_ack),
    .hit_o  (early_hit)
  );

  // next-state logic
  always_comb begin
    state_n = state_q;
    en_n    = en_q;
    pend_n  = pend_q;
    src_n   = src_q;
    dst_n   = dst_q;
    rem_n   = rem_q;
    len_n   = len_q;
    finish  = 1'b0;
    if (!en_q) begin
      if (arm) begin
        en_n   = 1'b1;
        pend_n = 1'b0;
        src_n  = cfg_src_addr;
        dst_n  = cfg_dst_addr;
        rem_n  = cfg_count;
        len_n  = cfg_count;
      end
    end else begin
      if (trig && state_q != ST_IDLE) pend_n = 1'b1;
      case (state_q)
        ST_IDLE: begin
          if (trig || pend_q) begin
            pend_n = 1'b0;
            if (rem_q == '0) finish = 1'b1;
            else             state_n = ST_READ;
          end
        end
        ST_READ: begin
          if (mem_ack) state_n = ST_WRITE;
        end
        ST_WRITE: begin
          if (mem_ack) begin
            src_n = side_nxt[0];
            dst_n = side_nxt[1];
            rem_n = rem_dec;
            if (rem_dec == '0) begin
              finish  = 1'b1;
              state_n = ST_IDLE;
            end else begin
              state_n = blk ? ST_READ : ST_IDLE;
            end
          end
        end
        default: state_n = ST_IDLE;
      endcase
      if (finish) begin
        if (rpt) begin
          src_n = cfg_src_addr;
          dst_n = cfg_dst_addr;
          rem_n = cfg_count;
          len_n = cfg_count;
        end else begin
          en_n   = 1'b0;
          pend_n = 1'b0;
        end
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      en_q    <= 1'b0;
      pend_q  <= 1'b0;
      src_q   <= '0;
      dst_q   <= '0;
      rem_q   <= '0;
      len_q   <= '0;
      done_q  <= 1'b0;
      early_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      en_q    <= en_n;
      pend_q  <= pend_n;
      src_q   <= src_n;
      dst_q   <= dst_n;
      rem_q   <= rem_n;
      len_q   <= len_n;
      done_q  <= finish;
      early_q <= early_hit;
      err_q   <= mem_req && mem_ack && mem_err;
    end
  end

  // read data holding register, enabled by the read acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (rd_ack) data_q <= mem_rdata;
  end

  assign mem_req     = en_q && (state_q != ST_IDLE);
  assign mem_we      = (state_q == ST_WRITE);
  assign mem_addr    = mem_we ? dst_q : src_q;
  assign mem_size    = mem_we ? cfg_dst_width : cfg_src_width;
  assign mem_wdata   = data_q;
  assign chan_active = en_q;
  assign done_pulse  = done_q;
  assign early_pulse = early_q;
  assign err_flag    = err_q;
  assign cur_src     = src_q;
  assign cur_dst     = dst_q;
  assign rem_cnt     = rem_q;

  // assertions
  a_r14_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_size));

  a_r2_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_active |-> !mem_req);

  a_r8_done_drops_enable: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse && !$past(cfg_mode[1]) |-> !chan_active);

  a_r11_repeat_keeps_enable: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse && $past(cfg_mode[1]) |-> chan_active);

  a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ack && (rem_cnt > CW'(1)) |=> rem_cnt == $past(rem_cnt) - CW'(1));

  a_r10_early_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(early_pulse && done_pulse));

endmodule

// File: tb/dma_chan_engine_test.sv
`timescale 1ns/1ps
module dma_chan_engine_test;

  localparam int AW = 32;
  localparam int DW = 64;
  localparam int CW = 16;
  localparam int LOGN = 2048;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          arm = 1'b0, hw_trig = 1'b0, sw_start = 1'b0;
  logic [1:0]    cfg_mode = 2'd1;
  logic [AW-1:0] cfg_src_addr = '0, cfg_dst_addr = '0;
  logic [1:0]    cfg_src_width = 2'd0, cfg_dst_width = 2'd0;
  logic [3:0]    cfg_src_inc = 4'd2, cfg_dst_inc = 4'd2;
  logic [CW-1:0] cfg_count = '0;
  logic [2:0]    cfg_early = 3'd0;
  logic          mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [1:0]    mem_size;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          mem_err = 1'b0;
  logic          chan_active, done_pulse, early_pulse, err_flag;
  logic [AW-1:0] cur_src, cur_dst;
  logic [CW-1:0] rem_cnt;

  logic ack_slow = 1'b0;
  logic ack_gate = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) ack_gate <= ~ack_gate;

  assign mem_ack   = mem_req & (ack_gate | ~ack_slow);
  assign mem_rdata = {~mem_addr, mem_addr};

  dma_chan_engine #(.AW(AW), .DW(DW), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .hw_trig(hw_trig), .sw_start(sw_start),
    .cfg_mode(cfg_mode), .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr),
    .cfg_src_width(cfg_src_width), .cfg_dst_width(cfg_dst_width),
    .cfg_src_inc(cfg_src_inc), .cfg_dst_inc(cfg_dst_inc), .cfg_count(cfg_count),
    .cfg_early(cfg_early), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .mem_err(mem_err), .chan_active(chan_active), .done_pulse(done_pulse),
    .early_pulse(early_pulse), .err_flag(err_flag), .cur_src(cur_src),
    .cur_dst(cur_dst), .rem_cnt(rem_cnt)
  );

  // traffic log, sampled at the falling edge
  logic [AW-1:0] rd_addr [LOGN];
  logic [1:0]    rd_size [LOGN];
  logic [AW-1:0] wr_addr [LOGN];
  logic [1:0]    wr_size [LOGN];
  logic [DW-1:0] wr_data [LOGN];
  int rd_n = 0, wr_n = 0, done_n = 0, early_n = 0, err_n = 0;
  logic [CW-1:0] early_rem = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req && mem_ack) begin
        if (!mem_we) begin
          rd_addr[rd_n % LOGN] = mem_addr;
          rd_size[rd_n % LOGN] = mem_size;
          rd_n++;
        end else begin
          wr_addr[wr_n % LOGN] = mem_addr;
          wr_size[wr_n % LOGN] = mem_size;
          wr_data[wr_n % LOGN] = mem_wdata;
          wr_n++;
        end
      end
      if (done_pulse) done_n++;
      if (early_pulse) begin
        early_n++;
        early_rem = rem_cnt;
      end
      if (err_flag) err_n++;
    end
  end

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic longint step_of(input int inc, input int w);
    longint e = longint'(1) << w;
    if (inc == 1) return -e;
    if (inc == 2) return e;
    if (inc >= 3 && inc <= 10) return longint'(inc - 1) * e;
    return 0;
  endfunction

  function automatic logic [AW-1:0] addr_at(input logic [AW-1:0] base, input longint st, input int k);
    return AW'(longint'(base) + st * k);
  endfunction

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_arm();
    @(negedge clk) arm = 1'b1;
    @(negedge clk) arm = 1'b0;
  endtask

  task automatic fire(input bit use_sw);
    @(negedge clk);
    if (use_sw) sw_start = 1'b1; else hw_trig = 1'b1;
    @(negedge clk);
    sw_start = 1'b0;
    hw_trig  = 1'b0;
  endtask

  task automatic wait_done(input int target);
    for (int i = 0; i < 4000 && done_n < target; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_writes(input int target);
    for (int i = 0; i < 1000 && wr_n < target; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic setup(input int mode, input int sw, input int dw, input int si, input int di,
                       input int cnt, input int early, input logic [AW-1:0] s, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_mode = 2'(mode); cfg_src_width = 2'(sw); cfg_dst_width = 2'(dw);
    cfg_src_inc = 4'(si); cfg_dst_inc = 4'(di); cfg_count = CW'(cnt);
    cfg_early = 3'(early); cfg_src_addr = s; cfg_dst_addr = d;
  endtask

  // one block with N elements, checked against arithmetic expectations
  task automatic sweep_run(input int mode, input int w, input int si, input int n);
    int rb, wb, db;
    bit ok_a, ok_d;
    longint ss, ds;
    logic [AW-1:0] s, d;
    int di;
    di = (si + 3) % 11;
    s  = 32'h0001_0000;
    d  = 32'h0008_0000;
    ss = step_of(si, w);
    ds = step_of(di, 3 - w);
    setup(mode, w, 3 - w, si, di, n, 0, s, d);
    rb = rd_n; wb = wr_n; db = done_n;
    pulse_arm();
    if (mode == 1) begin
      fire(1'b0);
    end else begin
      for (int k = 0; k < n; k++) begin
        if (k == n - 1)
          check(done_n == db && chan_active, "R4 single not done early", done_n - db, 0);
        fire(k[0]);
        wait_writes(wb + k + 1);
      end
    end
    wait_done(db + 1);
    ok_a = (rd_n - rb == n) && (wr_n - wb == n);
    ok_d = ok_a;
    for (int k = 0; k < n; k++) begin
      if (rd_addr[(rb + k) % LOGN] != addr_at(s, ss, k) || rd_size[(rb + k) % LOGN] != 2'(w))
        ok_a = 1'b0;
      if (wr_addr[(wb + k) % LOGN] != addr_at(d, ds, k) || wr_size[(wb + k) % LOGN] != 2'(3 - w))
        ok_a = 1'b0;
      if (wr_data[(wb + k) % LOGN] != {~addr_at(s, ss, k), addr_at(s, ss, k)})
        ok_d = 1'b0;
    end
    check(ok_a, "R6 addresses/sizes", rd_addr[rb % LOGN], s);
    check(ok_d, "R5 write data", wr_data[wb % LOGN], {~s, s});
    check(done_n == db + 1 && !chan_active, mode == 1 ? "R3 block done" : "R4 single done",
          done_n - db, 1);
    check(cur_src == addr_at(s, ss, n) && cur_dst == addr_at(d, ds, n), "R6 final addresses",
          cur_src, addr_at(s, ss, n));
  endtask

  initial begin
    int rb, wb, db, eb, xb;
    int thr_tab [8];
    thr_tab = '{0, 1, 2, 4, 8, 32, 64, 35};

    // R1 reset state
    @(negedge clk);
    check(!mem_req && !chan_active && !done_pulse && !early_pulse && !err_flag,
          "R1 reset outputs", {mem_req, chan_active, done_pulse, early_pulse}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 triggers before arm are ignored
    setup(1, 0, 0, 2, 2, 4, 0, 32'h100, 32'h200);
    fire(1'b0);
    fire(1'b1);
    repeat (8) @(negedge clk);
    check(rd_n == 0 && wr_n == 0 && !chan_active, "R2 no transfer before arm", rd_n, 0);

    // R3..R6 sweep: modes, widths, step codes, fast and throttled acknowledge
    for (int sl = 0; sl < 2; sl++) begin
      ack_slow = sl[0];
      for (int mode = 0; mode < 2; mode++)
        for (int w = 0; w < 4; w++)
          for (int si = 0; si < 11; si++)
            sweep_run(mode, w, si, 3);
    end
    ack_slow = 1'b0;

    // R2 arm ignored while enabled (single mode, one element left pending)
    do_reset();
    setup(0, 0, 0, 2, 2, 2, 0, 32'h400, 32'h500);
    pulse_arm();
    fire(1'b0);
    wait_writes(wr_n + 1);
    setup(0, 0, 0, 2, 2, 2, 0, 32'h900, 32'h500);
    pulse_arm();
    check(cur_src == 32'h401 && rem_cnt == 1, "R2 arm ignored when enabled", cur_src, 32'h401);

    // R9 zero count
    do_reset();
    setup(1, 2, 2, 2, 2, 0, 0, 32'h1000, 32'h2000);
    rb = rd_n; db = done_n;
    pulse_arm();
    fire(1'b0);
    wait_done(db + 1);
    check(rd_n == rb && done_n == db + 1 && !chan_active, "R9 zero count", rd_n - rb, 0);

    // R10 early warning sweep over all codes, count 70
    for (int code = 0; code < 8; code++) begin
      do_reset();
      setup(1, 0, 0, 2, 2, 70, code, 32'h3000, 32'h4000);
      eb = early_n; db = done_n;
      pulse_arm();
      fire(1'b0);
      wait_done(db + 1);
      check(early_n - eb == (code == 0 ? 0 : 1), "R10 early pulse count", early_n - eb,
            code == 0 ? 0 : 1);
      if (code != 0)
        check(early_rem == CW'(thr_tab[code]), "R10 early threshold", early_rem, thr_tab[code]);
    end
    // R10 count below threshold: no pulse
    do_reset();
    setup(1, 0, 0, 2, 2, 20, 5, 32'h3000, 32'h4000);
    eb = early_n; db = done_n;
    pulse_arm();
    fire(1'b0);
    wait_done(db + 1);
    check(early_n == eb, "R10 count below threshold", early_n - eb, 0);

    // R11 repeat block: reload, stay enabled
    do_reset();
    setup(3, 1, 1, 2, 2, 2, 0, 32'h5000, 32'h6000);
    db = done_n;
    pulse_arm();
    fire(1'b0);
    wait_done(db + 1);
    check(chan_active && cur_src == 32'h5000 && cur_dst == 32'h6000 && rem_cnt == 2,
          "R11 repeat block reload", cur_src, 32'h5000);

    // R12 trigger coinciding with final write of a repeat block
    rb = rd_n; db = done_n;
    fire(1'b0);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (mem_req && mem_we && mem_ack && rem_cnt == 1) break;
    end
    hw_trig = 1'b1;
    @(negedge clk) hw_trig = 1'b0;
    wait_done(db + 2);
    check(done_n == db + 2 && rd_n - rb == 4, "R12 coincident trigger second block", rd_n - rb, 4);
    check(rd_addr[(rb + 2) % LOGN] == 32'h5000 && rd_addr[(rb + 3) % LOGN] == 32'h5002,
          "R12 second block restarts", rd_addr[(rb + 2) % LOGN], 32'h5000);

    // R11 repeat single
    do_reset();
    setup(2, 0, 0, 2, 2, 2, 0, 32'h7000, 32'h7800);
    db = done_n; wb = wr_n;
    pulse_arm();
    fire(1'b1);
    wait_writes(wb + 1);
    fire(1'b0);
    wait_done(db + 1);
    check(chan_active && rem_cnt == 2 && cur_src == 32'h7000, "R11 repeat single reload",
          rem_cnt, 2);

    // R12 trigger while element in flight (single, throttled)
    do_reset();
    ack_slow = 1'b1;
    setup(0, 0, 0, 2, 2, 2, 0, 32'h7000, 32'h7800);
    db = done_n; wb = wr_n;
    pulse_arm();
    fire(1'b0);
    fire(1'b0);
    wait_done(db + 1);
    check(wr_n - wb == 2 && done_n == db + 1 && !chan_active, "R12 pending trigger in single",
          wr_n - wb, 2);
    ack_slow = 1'b0;

    // R13 error pass-through
    do_reset();
    setup(1, 2, 2, 2, 2, 3, 0, 32'h8000, 32'h9000);
    xb = err_n; db = done_n; wb = wr_n;
    mem_err = 1'b1;
    pulse_arm();
    fire(1'b0);
    wait_done(db + 1);
    mem_err = 1'b0;
    check(err_n - xb == 6 && wr_n - wb == 3, "R13 error flag pulses", err_n - xb, 6);

    // R7 count drop after one single-mode element
    do_reset();
    setup(0, 0, 0, 2, 2, 5, 0, 32'h100, 32'h200);
    wb = wr_n;
    pulse_arm();
    check(rem_cnt == 5, "R7 count loaded", rem_cnt, 5);
    fire(1'b0);
    wait_writes(wb + 1);
    check(rem_cnt == 4, "R7 count decrement", rem_cnt, 4);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule